// File: doc/BRIEF.md
# Transaction Ordering Receive Reorder Arbiter

This block sits behind the receive side of a packet link. It takes headers that an upstream stage has already classified, stamps each one with its arrival order, and parks it in one of three class queues: posted requests, non-posted requests and completions. Each cycle an arbiter looks at the three queue heads. It issues the one that the pair-wise ordering rules and the header's relaxed-ordering flag allow to go first. A later header therefore overtakes an earlier one only when the rules permit it. Payload storage stays with the consumer.

The consumer applies back-pressure in two ways. The issue port has a valid/ready pair. There is also one downstream-ready bit per class, which gates whether that class's head may be chosen at all. Arrival stamps are free-running and wrap. Age is decided by modular comparison, and the stamp is one bit wider than needed to count every entry the block can hold.

Top module: `txn_reorder_arb`

## Requirements
- R1: A synchronous active-high reset empties all queues, clears the arrival stamp to 0 and drops `out_valid`. After reset, `in_ready` is high for every kind code.
- R2: Kind codes are 0 = posted, 1 = non-posted, 2 = completion. Each class queue holds 8 headers. `in_ready` is low while the queue of the presented kind is full, and high for the other kinds.
- R3: Within one class, headers are issued in the order they were accepted. This holds whatever their relaxed-ordering flags are.
- R4: The head of the posted queue may be issued ahead of older non-posted requests and older completions.
- R5: A completion whose relaxed-ordering flag is 0 is never issued while an older posted request is still queued. With the flag at 1, it may pass that posted request.
- R6: A non-posted request is never issued while an older posted request or an older completion is still queued.
- R7: A class head is eligible only while its bit of `dn_rdy` is 1. Bit 0 is posted, bit 1 is non-posted and bit 2 is completion.
- R8: When several heads are eligible, the order of preference is posted, then completion, then non-posted.
- R9: A head that is blocked by an older entry in another queue does not prevent a different, eligible queue head from issuing.
- R10: At most one header is issued per clock. The issue port is registered. While `out_valid` is 1 and `out_ready` is 0, the outputs hold steady.
- R11: Each stored header carries a 6-bit stamp (default depth). The stamp counts accepted headers modulo 64 and is presented on `out_stamp`. Ordering stays correct across stamp wrap-around.
- R12: Kind code 3 is accepted (`in_ready` high), then discarded. It is never issued and it does not advance the stamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Header presented |
| in_ready | output | 1 | Header can be accepted this cycle |
| in_kind | input | 2 | Class code of the presented header |
| in_ro | input | 1 | Relaxed-ordering flag |
| in_tid | input | TID_W | Transaction identifier |
| dn_rdy | input | 3 | Per-class downstream readiness |
| out_valid | output | 1 | Issued header valid |
| out_ready | input | 1 | Consumer takes the issued header |
| out_kind | output | 2 | Class code of the issued header |
| out_ro | output | 1 | Relaxed-ordering flag of the issued header |
| out_tid | output | TID_W | Transaction identifier of the issued header |
| out_stamp | output | STAMP_W | Arrival stamp of the issued header |

## Verification
A corrupted queue pointer or count shows up on the issue port within a few cycles of the next drain, as a wrong or repeated `out_tid`. It also shows as an `in_ready` that falls at the wrong fill level. A wrong age comparison shows only when two classes hold entries at once. For that reason, the directed scenarios stage mixed classes behind a closed `dn_rdy` and then open it. A long random phase wraps the stamp many times, so a modular-compare error appears as an out-of-order issue against the reference queues on the first cycle it happens.

// File: rtl/txn_ord_pkg.sv
package txn_ord_pkg;
  localparam int NUM_Q = 3;

  typedef enum logic [1:0] {
    K_POSTED  = 2'd0,
    K_NONPOST = 2'd1,
    K_CPL     = 2'd2,
    K_RSVD    = 2'd3
  } kind_e;
endpackage

// File: rtl/txn_hdr_fifo.sv
module txn_hdr_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [PTR_W:0]    count;

  assign full    = (count == (PTR_W+1)'(DEPTH));
  assign empty   = (count == '0);
  assign rd_data = mem[rptr];

  // storage without reset so the array maps to RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_en) wptr <= (wptr == PTR_W'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (rd_en) rptr <= (rptr == PTR_W'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full) else $error("R2 write into full queue");

  a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty) else $error("R3 read from empty queue");
endmodule

// File: rtl/txn_order_pick.sv
module txn_order_pick #(
  parameter int STAMP_W = 6
) (
  input  logic               p_vld,
  input  logic               n_vld,
  input  logic               c_vld,
  input  logic [STAMP_W-1:0] p_st,
  input  logic [STAMP_W-1:0] n_st,
  input  logic [STAMP_W-1:0] c_st,
  input  logic               c_ro,
  input  logic [2:0]         dn_rdy,
  output logic [2:0]         grant,
  output logic               any
);
  // a is older than b when (a - b) is negative modulo 2**STAMP_W
  function automatic logic older(input logic [STAMP_W-1:0] a,
                                 input logic [STAMP_W-1:0] b);
    logic [STAMP_W-1:0] d;
    d = a - b;
    return d[STAMP_W-1];
  endfunction

  logic el_p, el_n, el_c;

  always_comb begin
    el_p = p_vld && dn_rdy[0];
    el_c = c_vld && dn_rdy[2] && (c_ro || !p_vld || !older(p_st, c_st));
    el_n = n_vld && dn_rdy[1]
           && (!p_vld || !older(p_st, n_st))
           && (!c_vld || !older(c_st, n_st));
    grant = 3'b000;
    if (el_p)      grant[0] = 1'b1;
    else if (el_c) grant[2] = 1'b1;
    else if (el_n) grant[1] = 1'b1;
    any = el_p || el_c || el_n;
  end
endmodule

// File: rtl/txn_reorder_arb.sv
module txn_reorder_arb
  import txn_ord_pkg::*;
#(
  parameter int TID_W   = 16,
  parameter int Q_DEPTH = 8,
  localparam int STAMP_W = $clog2(NUM_Q * Q_DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [1:0]         in_kind,
  input  logic               in_ro,
  input  logic [TID_W-1:0]   in_tid,
  input  logic [2:0]         dn_rdy,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [1:0]         out_kind,
  output logic               out_ro,
  output logic [TID_W-1:0]   out_tid,
  output logic [STAMP_W-1:0] out_stamp
);
  localparam int ENT_W = TID_W + 1 + STAMP_W;

  logic [NUM_Q-1:0] q_full, q_empty, q_push, q_pop;
  logic [ENT_W-1:0] q_head [NUM_Q];
  logic [STAMP_W-1:0] stamp_q;
  logic [ENT_W-1:0] new_ent, sel_ent;
  logic [1:0] sel_kind;
  logic [2:0] grant;
  logic any, issue_en, fire;
  logic [STAMP_W-1:0] p_st, n_st, c_st;

  assign new_ent  = {in_tid, in_ro, stamp_q};
  assign issue_en = !out_valid || out_ready;

  always_comb begin
    case (kind_e'(in_kind))
      K_POSTED:  in_ready = !q_full[0];
      K_NONPOST: in_ready = !q_full[1];
      K_CPL:     in_ready = !q_full[2];
      default:   in_ready = 1'b1;
    endcase
  end

  assign fire = in_valid && in_ready && (kind_e'(in_kind) != K_RSVD);

  for (genvar i = 0; i < NUM_Q; i++) begin : g_q
    assign q_push[i] = in_valid && in_ready && (in_kind == 2'(i));
    assign q_pop[i]  = grant[i] && issue_en;
    txn_hdr_fifo #(.DATA_W(ENT_W), .DEPTH(Q_DEPTH)) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (q_push[i]),
      .wr_data (new_ent),
      .rd_en   (q_pop[i]),
      .rd_data (q_head[i]),
      .full    (q_full[i]),
      .empty   (q_empty[i])
    );
  end

  assign p_st = q_head[0][STAMP_W-1:0];
  assign n_st = q_head[1][STAMP_W-1:0];
  assign c_st = q_head[2][STAMP_W-1:0];

  txn_order_pick #(.STAMP_W(STAMP_W)) u_pick (
    .p_vld  (!q_empty[0]),
    .n_vld  (!q_empty[1]),
    .c_vld  (!q_empty[2]),
    .p_st   (p_st),
    .n_st   (n_st),
    .c_st   (c_st),
    .c_ro   (q_head[2][STAMP_W]),
    .dn_rdy (dn_rdy),
    .grant  (grant),
    .any    (any)
  );

  always_comb begin
    sel_ent  = q_head[1];
    sel_kind = 2'd1;
    if (grant[0]) begin
      sel_ent  = q_head[0];
      sel_kind = 2'd0;
    end else if (grant[2]) begin
      sel_ent  = q_head[2];
      sel_kind = 2'd2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stamp_q <= '0;
    end else if (fire) begin
      stamp_q <= stamp_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_kind  <= '0;
      out_ro    <= 1'b0;
      out_tid   <= '0;
      out_stamp <= '0;
    end else if (issue_en) begin
      out_valid <= any;
      if (any) begin
        out_kind  <= sel_kind;
        out_ro    <= sel_ent[STAMP_W];
        out_tid   <= sel_ent[ENT_W-1:STAMP_W+1];
        out_stamp <= sel_ent[STAMP_W-1:0];
      end
    end
  end

  // age differences observed between queue heads, for the order checks
  logic [STAMP_W-1:0] d_cp, d_np, d_nc;
  assign d_cp = c_st - p_st;
  assign d_np = n_st - p_st;
  assign d_nc = n_st - c_st;

  a_r5_cpl_behind_posted: assert property (@(posedge clk) disable iff (rst)
    (grant[2] && !q_head[2][STAMP_W] && !q_empty[0]) |-> d_cp[STAMP_W-1])
    else $error("R5 strict completion passed older posted");

  a_r6_np_behind_posted: assert property (@(posedge clk) disable iff (rst)
    (grant[1] && !q_empty[0]) |-> d_np[STAMP_W-1])
    else $error("R6 non-posted passed older posted");

  a_r6_np_behind_cpl: assert property (@(posedge clk) disable iff (rst)
    (grant[1] && !q_empty[2]) |-> d_nc[STAMP_W-1])
    else $error("R6 non-posted passed older completion");

  a_r7_dn_gate: assert property (@(posedge clk) disable iff (rst)
    any |-> |(grant & dn_rdy))
    else $error("R7 grant to class without downstream ready");

  a_r8_posted_first: assert property (@(posedge clk) disable iff (rst)
    (grant[2] || grant[1]) |-> (q_empty[0] || !dn_rdy[0]))
    else $error("R8 posted head skipped while eligible");

  a_r10_one_pop: assert property (@(posedge clk) disable iff (rst)
    $onehot0(q_pop)) else $error("R10 more than one issue per clock");

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_tid)
      && $stable(out_kind) && $stable(out_stamp)))
    else $error("R10 issue port changed under back-pressure");

  a_r12_rsvd_no_stamp: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 2'd3) |=> $stable(stamp_q))
    else $error("R12 reserved kind advanced stamp");
endmodule

// File: tb/sim_txn_reorder_arb.sv
module sim_txn_reorder_arb;
  localparam int TID_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_ro = 1'b0, out_ready = 1'b1;
  logic [1:0] in_kind = 2'd0;
  logic [TID_W-1:0] in_tid = '0;
  logic [2:0] dn_rdy = 3'b000;
  logic in_ready, out_valid, out_ro;
  logic [1:0] out_kind;
  logic [TID_W-1:0] out_tid;
  logic [5:0] out_stamp;

  always #2 clk = ~clk;

  txn_reorder_arb #(.TID_W(TID_W), .Q_DEPTH(8)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_ro(in_ro), .in_tid(in_tid), .dn_rdy(dn_rdy),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_ro(out_ro), .out_tid(out_tid), .out_stamp(out_stamp)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // behavioural reference: one queue per class, unbounded arrival count
  int p_tid[$], p_ro[$], p_seq[$];
  int n_tid[$], n_ro[$], n_seq[$];
  int c_tid[$], c_ro[$], c_seq[$];
  int seq = 0;
  bit e_valid = 0;
  int e_kind, e_ro, e_tid, e_seq;
  int log_q[$];

  function automatic bit m_rdy(input logic [1:0] k);
    case (k)
      2'd0: return p_tid.size() < 8;
      2'd1: return n_tid.size() < 8;
      2'd2: return c_tid.size() < 8;
      default: return 1'b1;
    endcase
  endfunction

  always @(posedge clk) begin
    bit ep, ec, en, rdy;
    if (rst) begin
      p_tid.delete(); p_ro.delete(); p_seq.delete();
      n_tid.delete(); n_ro.delete(); n_seq.delete();
      c_tid.delete(); c_ro.delete(); c_seq.delete();
      seq = 0; e_valid = 0;
    end else begin
      if (out_valid && out_ready) log_q.push_back(int'(out_tid));
      rdy = m_rdy(in_kind);
      ep = p_tid.size() > 0 && dn_rdy[0];
      ec = c_tid.size() > 0 && dn_rdy[2] &&
           (c_ro[0] == 1 || p_tid.size() == 0 || c_seq[0] < p_seq[0]);
      en = n_tid.size() > 0 && dn_rdy[1] &&
           (p_tid.size() == 0 || n_seq[0] < p_seq[0]) &&
           (c_tid.size() == 0 || n_seq[0] < c_seq[0]);
      if (!e_valid || out_ready) begin
        e_valid = ep || ec || en;
        if (ep) begin
          e_kind = 0; e_tid = p_tid.pop_front(); e_ro = p_ro.pop_front(); e_seq = p_seq.pop_front();
        end else if (ec) begin
          e_kind = 2; e_tid = c_tid.pop_front(); e_ro = c_ro.pop_front(); e_seq = c_seq.pop_front();
        end else if (en) begin
          e_kind = 1; e_tid = n_tid.pop_front(); e_ro = n_ro.pop_front(); e_seq = n_seq.pop_front();
        end
      end
      if (in_valid && rdy && in_kind != 2'd3) begin
        case (in_kind)
          2'd0: begin p_tid.push_back(int'(in_tid)); p_ro.push_back(int'(in_ro)); p_seq.push_back(seq); end
          2'd1: begin n_tid.push_back(int'(in_tid)); n_ro.push_back(int'(in_ro)); n_seq.push_back(seq); end
          default: begin c_tid.push_back(int'(in_tid)); c_ro.push_back(int'(in_ro)); c_seq.push_back(seq); end
        endcase
        seq++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference, after the edge has settled
  always @(posedge clk) begin
    #1;
    if (!rst && !done) begin
      chk(in_ready == m_rdy(in_kind), "R2 in_ready vs model", int'(in_ready), int'(m_rdy(in_kind)));
      chk(out_valid == e_valid, "R10 out_valid vs model", int'(out_valid), int'(e_valid));
      if (out_valid && e_valid) begin
        chk(int'(out_tid) == e_tid && int'(out_kind) == e_kind && int'(out_ro) == e_ro,
            "R3/R5/R6 issued header vs model", int'(out_tid), e_tid);
        chk(int'(out_stamp) == (e_seq % 64), "R11 stamp vs model", int'(out_stamp), e_seq % 64);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; dn_rdy = 3'b000; out_ready = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    log_q.delete();
  endtask

  task automatic push(input logic [1:0] k, input logic ro, input int tid);
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_ro = ro; in_tid = TID_W'(tid);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_log(input string tag, input int exp[$]);
    bit ok;
    ok = (log_q.size() == exp.size());
    if (ok) foreach (exp[i]) if (log_q[i] != exp[i]) ok = 0;
    chk(ok, tag, log_q.size() > 0 ? log_q[0] : -1, exp.size() > 0 ? exp[0] : -1);
    log_q.delete();
  endtask

  task automatic finish_sim();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_sim();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    for (int k = 0; k < 4; k++) begin
      in_kind = 2'(k); #1;
      chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    end

    // R3 posted FIFO order regardless of relaxed flag
    push(2'd0, 0, 1); push(2'd0, 1, 2); push(2'd0, 0, 3);
    dn_rdy = 3'b111; idle(8);
    check_log("R3 posted order", '{1, 2, 3});

    // R4 and R8: posted passes older np and cpl; cpl before np
    do_reset();
    push(2'd1, 0, 10); push(2'd2, 0, 11); push(2'd0, 0, 12);
    dn_rdy = 3'b111; idle(8);
    check_log("R4 R8 posted first then cpl then np", '{12, 11, 10});

    // R5 relaxed completion passes posted, strict one waits
    do_reset();
    push(2'd0, 0, 20); push(2'd2, 1, 21); push(2'd2, 0, 22);
    dn_rdy = 3'b110; idle(8);
    check_log("R5 relaxed cpl passes, strict held", '{21});
    dn_rdy = 3'b111; idle(8);
    check_log("R5 remaining order", '{20, 22});

    // R9 and R6: np blocked behind posted, relaxed cpl still flows
    do_reset();
    push(2'd0, 0, 30); push(2'd1, 0, 31); push(2'd2, 1, 32);
    dn_rdy = 3'b110; idle(8);
    check_log("R9 unrelated cpl not stalled", '{32});
    dn_rdy = 3'b111; idle(8);
    check_log("R6 np after posted", '{30, 31});

    // R6 np blocked behind older completion
    do_reset();
    push(2'd2, 0, 40); push(2'd1, 0, 41);
    dn_rdy = 3'b010; idle(8);
    check_log("R6 np held by older cpl", '{});
    dn_rdy = 3'b111; idle(8);
    check_log("R6 np after cpl", '{40, 41});

    // R7 downstream ready gating
    do_reset();
    push(2'd0, 0, 50);
    idle(6);
    chk(out_valid == 1'b0, "R7 gated class not issued", int'(out_valid), 0);
    dn_rdy = 3'b001; idle(6);
    check_log("R7 issued once ready", '{50});

    // R2 full queue back-pressure per class
    do_reset();
    for (int i = 0; i < 8; i++) push(2'd0, 0, 100 + i);
    in_kind = 2'd0; #1;
    chk(in_ready == 1'b0, "R2 posted full", int'(in_ready), 0);
    in_kind = 2'd1; #1;
    chk(in_ready == 1'b1, "R2 other class open", int'(in_ready), 1);
    dn_rdy = 3'b111; idle(14);
    check_log("R2 all eight drained in order", '{100, 101, 102, 103, 104, 105, 106, 107});

    // R12 reserved kind discarded, stamp untouched
    do_reset();
    push(2'd3, 0, 70); push(2'd3, 1, 71);
    push(2'd0, 0, 72);
    dn_rdy = 3'b111;
    @(posedge clk); #1;
    chk(out_valid && out_stamp == 6'd0, "R12 first real header stamp", int'(out_stamp), 0);
    idle(6);
    check_log("R12 reserved never issued", '{72});

    // R10 hold under back-pressure
    do_reset();
    out_ready = 1'b0; dn_rdy = 3'b111;
    push(2'd0, 0, 60); push(2'd0, 0, 61);
    idle(5);
    chk(out_valid && out_tid == 16'd60, "R10 held header", int'(out_tid), 60);
    out_ready = 1'b1; idle(6);
    check_log("R10 release order", '{60, 61});

    // R11 random traffic, stamps wrap many times
    do_reset();
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      in_valid  = 1'($urandom % 2);
      in_kind   = 2'($urandom % 4);
      in_ro     = 1'($urandom % 2);
      in_tid    = TID_W'($urandom);
      dn_rdy    = 3'($urandom);
      out_ready = ($urandom % 4) != 0;
    end
    @(negedge clk); in_valid = 1'b0;
    chk(seq > 128, "R11 stamp wrapped", seq, 128);
    idle(4);
    finish_sim();
  end
endmodule